// File: doc/BRIEF.md
# XOR-Matrix Redundant Array Multiplier

This block multiplies two unsigned N-bit operands in a single combinational path and returns the full 2N-bit product. Each partial-product bit is derived from an exclusive-OR matrix, with entry (i, n) equal to the XOR of operand bit x[n] and multiplier bit y[i]. Because that entry is the inverse of x[n] exactly when y[i] is set, the bit a row contributes is the row's y bit ANDed with the inverted matrix entry.

The rows are accumulated one after another in a redundant digit form. Each column holds a digit between -1 and +2. Each accumulator cell looks only at its own column and at a one-bit transfer from the column below, so no carry chain runs through the array. A final ripple stage with a signed carry converts the last redundant row to binary.

A concurrent checker computes the mod-3 residue of every intermediate stage. It compares that residue with the residue that the partially formed product should have, and raises `check_err_o` on any mismatch. A parameter can invert one stored digit bit, which serves for fault-injection studies.

Top module: `xor_array_mult`

## Requirements
- R1: For every pair of N-bit unsigned operands, `prod_o` equals x_i * y_i as a 2N-bit unsigned value.
- R2: Matrix entry (i, n) is x_i[n] XOR y_i[i]. The bit row i adds at column i+n is y_i[i] AND NOT of that entry, so y_i = 0 yields product 0 and y_i = 1 yields x_i.
- R3: A digit is the bit pair (u, r) with 00 = 0, 10 = +1, 01 = -1, 11 = +2. After row i, the weighted digit sum equals the value before the row plus y_i[i]*x_i*2^i, so a single set multiplier bit k gives x_i shifted left by k.
- R4: Each cell splits digit plus row bit (range -1..+3) into a transfer of 1 when the sum is at least 2, and keeps the rest. The new digit is the rest plus the transfer from the column below, which stays within -1..+2. No transfer ever leaves the widest column.
- R5: The final stage converts the digits to binary with a carry in {-1, 0, +1}, least significant column first. For fault-free operation, the carry out and all bits above 2N-1 are zero, including at the largest operands.
- R6: For every stage k, the digit sum of that stage taken mod 3 must equal (x_i mod 3)*((y_i mod 2^k) mod 3) mod 3. Any stage that breaks this drives `check_err_o` high, and for fault-free operation `check_err_o` is 0 for all inputs.
- R7: With FAULT_ROW = k (0..N-1) and FAULT_COL = c, the r bit of column c is inverted after row k. This changes the stage value by ±2^c, so `check_err_o` is 1 for every input pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | N | Multiplicand, unsigned |
| y_i | input | N | Multiplier, unsigned |
| prod_o | output | 2N | Unsigned product |
| check_err_o | output | 1 | High when any stage fails the mod-3 residue check |

## Verification
The assertions assume the operands are driven to known values and that FAULT_ROW and FAULT_COL are either disabled or lie inside the array. Under those assumptions, value conservation per row, the absence of a spill past 2N bits and the product equality all hold. The stimulus holds each operand pair steady for a full clock period and sweeps all 65536 pairs at N = 8. Two copies of the block are driven from the same inputs: one fault-free, and one with a digit bit inverted in a middle row. This exercises every reachable digit pattern in both the clean and the corrupted case.

// File: rtl/xmul_pkg.sv
package xmul_pkg;
  // digit code (u,r): 00=0, 10=+1, 01=-1, 11=+2
  function automatic logic signed [2:0] dig_val(input logic u, input logic r);
    case ({u, r})
      2'b10:   dig_val = 3'sd1;
      2'b01:   dig_val = -3'sd1;
      2'b11:   dig_val = 3'sd2;
      default: dig_val = 3'sd0;
    endcase
  endfunction

  function automatic int mod3(input int v);
    int m;
    m = v % 3;
    if (m < 0) m = m + 3;
    return m;
  endfunction
endpackage

// File: rtl/xmul_cell.sv
module xmul_cell
  import xmul_pkg::*;
(
  input  logic u_i,
  input  logic r_i,
  input  logic pp_i,
  input  logic t_i,
  output logic u_o,
  output logic r_o,
  output logic t_o
);
  logic signed [2:0] sum_s, rest_s, dig_s;

  always_comb begin
    sum_s  = dig_val(u_i, r_i) + $signed({2'b00, pp_i});
    t_o    = (sum_s >= 3'sd2);
    rest_s = t_o ? sum_s - 3'sd2 : sum_s;
    dig_s  = rest_s + $signed({2'b00, t_i});
    u_o    = (dig_s == 3'sd1) || (dig_s == 3'sd2);
    r_o    = (dig_s == -3'sd1) || (dig_s == 3'sd2);
  end
endmodule

// File: rtl/xmul_row.sv
module xmul_row
  import xmul_pkg::*;
#(
  parameter int N   = 8,
  parameter int W   = 2 * N + 2,
  parameter int ROW = 0
) (
  input  logic [N-1:0] x_i,
  input  logic         yb_i,
  input  logic [W-1:0] u_i,
  input  logic [W-1:0] r_i,
  output logic [W-1:0] u_o,
  output logic [W-1:0] r_o
);
  logic [W:0]   tr;
  logic [W-1:0] pp;

  assign tr[0] = 1'b0;

  for (genvar c = 0; c < W; c++) begin : g_col
    if (c >= ROW && c < ROW + N) begin : g_act
      logic e;
      assign e      = x_i[c-ROW] ^ yb_i;
      assign pp[c]  = yb_i & ~e;
    end else begin : g_idle
      assign pp[c]  = 1'b0;
    end
    xmul_cell u_cell (
      .u_i (u_i[c]),
      .r_i (r_i[c]),
      .pp_i(pp[c]),
      .t_i (tr[c]),
      .u_o (u_o[c]),
      .r_o (r_o[c]),
      .t_o (tr[c+1])
    );
  end

  int v_in, v_out;
  always_comb begin
    v_in  = 0;
    v_out = 0;
    for (int c = 0; c < W; c++) begin
      v_in  = v_in  + int'(dig_val(u_i[c], r_i[c])) * (1 << c);
      v_out = v_out + int'(dig_val(u_o[c], r_o[c])) * (1 << c);
    end
    p_row_sum_r3: assert (v_out == v_in + (yb_i ? int'(x_i) << ROW : 0))
      else $error("row %0d value not conserved", ROW);
    p_no_top_transfer_r4: assert (tr[W] == 1'b0)
      else $error("row %0d transfer lost at top", ROW);
  end
endmodule

// File: rtl/xmul_rca.sv
module xmul_rca
  import xmul_pkg::*;
#(
  parameter int W = 18
) (
  input  logic [W-1:0] u_i,
  input  logic [W-1:0] r_i,
  output logic [W-1:0] bin_o,
  output logic signed [1:0] cout_o
);
  logic signed [1:0] cy [W+1];
  assign cy[0] = 2'sd0;

  for (genvar c = 0; c < W; c++) begin : g_rc
    logic signed [2:0] t;
    assign t         = dig_val(u_i[c], r_i[c]) + {cy[c][1], cy[c]};
    assign bin_o[c]  = t[0];
    assign cy[c+1]   = t[2:1];
  end

  assign cout_o = cy[W];
endmodule

// File: rtl/xor_array_mult.sv
module xor_array_mult
  import xmul_pkg::*;
#(
  parameter int N         = 8,
  parameter int FAULT_ROW = -1,
  parameter int FAULT_COL = 0
) (
  input  logic [N-1:0]   x_i,
  input  logic [N-1:0]   y_i,
  output logic [2*N-1:0] prod_o,
  output logic           check_err_o
);
  localparam int W  = 2 * N + 2;
  localparam int PW = 2 * N;

  logic [W-1:0] su [N+1];
  logic [W-1:0] sr [N+1];
  logic [W-1:0] bin;
  logic signed [1:0] cout;

  assign su[0] = '0;
  assign sr[0] = '0;

  for (genvar k = 0; k < N; k++) begin : g_row
    localparam logic [W-1:0] FMASK =
      (FAULT_ROW == k) ? (W'(1) << FAULT_COL) : '0;
    logic [W-1:0] r_raw;
    xmul_row #(.N(N), .W(W), .ROW(k)) u_row (
      .x_i (x_i),
      .yb_i(y_i[k]),
      .u_i (su[k]),
      .r_i (sr[k]),
      .u_o (su[k+1]),
      .r_o (r_raw)
    );
    assign sr[k+1] = r_raw ^ FMASK;
  end

  xmul_rca #(.W(W)) u_rca (
    .u_i   (su[N]),
    .r_i   (sr[N]),
    .bin_o (bin),
    .cout_o(cout)
  );

  assign prod_o = bin[PW-1:0];

  // mod-3 residue check of every stage
  always_comb begin
    int rx, ry, rs;
    check_err_o = 1'b0;
    rx = 0;
    for (int n = 0; n < N; n++) rx = rx + ((n % 2 == 0) ? int'(x_i[n]) : -int'(x_i[n]));
    rx = mod3(rx);
    for (int k = 1; k <= N; k++) begin
      ry = 0;
      for (int n = 0; n < k; n++) ry = ry + ((n % 2 == 0) ? int'(y_i[n]) : -int'(y_i[n]));
      rs = 0;
      for (int c = 0; c < W; c++) begin
        if (c % 2 == 0) rs = rs + int'(dig_val(su[k][c], sr[k][c]));
        else            rs = rs - int'(dig_val(su[k][c], sr[k][c]));
      end
      if (mod3(rs) != mod3(rx * mod3(ry))) check_err_o = 1'b1;
    end
  end

  always_comb begin
    if (FAULT_ROW < 0) begin
      p_product_r1: assert (prod_o == {{N{1'b0}}, x_i} * {{N{1'b0}}, y_i})
        else $error("product mismatch");
      p_no_spill_r5: assert (cout == 2'sd0 && bin[W-1:PW] == '0)
        else $error("conversion spill");
      p_no_flag_r6: assert (!check_err_o)
        else $error("residue flag on clean array");
    end else begin
      p_fault_seen_r7: assert (check_err_o)
        else $error("injected fault not flagged");
    end
  end
endmodule

// File: tb/tb_xor_array_mult.sv
module tb_xor_array_mult;
  localparam int N = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]   x, y;
  logic [2*N-1:0] prod, prod_f;
  logic           err, err_f;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  xor_array_mult #(.N(N)) dut (
    .x_i(x), .y_i(y), .prod_o(prod), .check_err_o(err)
  );

  xor_array_mult #(.N(N), .FAULT_ROW(3), .FAULT_COL(5)) dut_flt (
    .x_i(x), .y_i(y), .prod_o(prod_f), .check_err_o(err_f)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s x=%0d y=%0d actual=%0d expected=%0d", req, x, y, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b);
    @(negedge clk);
    x = N'(a);
    y = N'(b);
    #1;
  endtask

  task automatic t_idle;
    apply(0, 0);
    chk(prod == 0, "R1", int'(prod), 0);
    chk(err == 0, "R6", int'(err), 0);
  endtask

  task automatic t_matrix;
    apply(8'hA5, 0);
    chk(prod == 0, "R2", int'(prod), 0);
    apply(8'hA5, 1);
    chk(prod == 16'h00A5, "R2", int'(prod), 'hA5);
    apply(0, 8'hFF);
    chk(prod == 0, "R2", int'(prod), 0);
  endtask

  task automatic t_single_rows;
    for (int k = 0; k < N; k++) begin
      apply(8'hC3, 1 << k);
      chk(int'(prod) == ('hC3 << k), "R3", int'(prod), 'hC3 << k);
    end
  endtask

  task automatic t_corners;
    apply(255, 255);
    chk(int'(prod) == 65025, "R4", int'(prod), 65025);
    chk(int'(prod) == 65025, "R5", int'(prod), 65025);
    apply(128, 255);
    chk(int'(prod) == 32640, "R5", int'(prod), 32640);
    apply(255, 1);
    chk(int'(prod) == 255, "R4", int'(prod), 255);
  endtask

  task automatic t_exhaustive;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        apply(a, b);
        chk(int'(prod) == a * b, "R1", int'(prod), a * b);
        chk(err == 1'b0, "R6", int'(err), 0);
        chk(err_f == 1'b1, "R7", int'(err_f), 1);
      end
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish_run();
    end
  end

  initial begin
    x = '0;
    y = '0;
    repeat (2) @(posedge clk);
    t_idle();
    t_matrix();
    t_single_rows();
    t_corners();
    t_exhaustive();
    finish_run();
  end
endmodule